// File: doc/BRIEF.md
# Dual-Rate Two-Bank Sensor FIFO

This block stores sensor samples that arrive on a slow sampling clock and delivers them, a whole frame at a time, to a transmitter running on a fast baseband clock. It has two storage banks. The slow bank takes one sample per slow-clock cycle whenever the sample strobe is high. It is split into two halves that are filled in turn. When a half is full, that half forms one frame and is handed to the fast domain. Writing then moves on to the other half, so sampling never stalls.

The fast domain learns of a filled half through a toggle signal that passes through a two-flop synchroniser. It then copies the frame, one word per fast cycle, into a frame slot in the fast bank. An acknowledgement toggle goes back through a second synchroniser to the slow side. The fast bank holds several frames. While at least one complete frame is stored, the block holds a wake request to the transmitter. The transmitter pulls words out oldest first, using a pop strobe.

A frame may finish while every fast slot is still occupied. That frame is then discarded, and a sticky overflow flag is raised. The frames already stored are kept intact.

Top module: `dual_rate_sensor_fifo`

## Requirements
- R1: After both resets, `tx_wake` and `ovf_flag` are low and no frame is stored.
- R2: A sample is written on each rising edge of `clk_s` at which `smp_valid` is high. Writes fill the two halves of the slow bank in turn, each half holding FRAME = SLOW_DEPTH/2 samples. When the last word of a half is written, that half becomes one frame and is handed to the fast domain.
- R3: `tx_wake` is high exactly while at least one complete frame sits in the fast bank. It rises a bounded number of `clk_f` cycles after a frame is handed over, and it falls once the last word of the last stored frame has been popped.
- R4: `tx_data` shows the oldest unread word while `tx_wake` is high. Each `clk_f` edge with `tx_pop` high and `tx_wake` high moves to the next word. Words come out in exact arrival order, across frame boundaries.
- R5: `tx_pop` while `tx_wake` is low has no effect. No word is skipped, and the next frame is read from its first sample.
- R6: Samples written on consecutive slow cycles, across a handover, are all kept. No gap in `smp_valid` is needed while a copy runs.
- R7: The fast bank holds NSLOT = FAST_DEPTH/FRAME frames. A frame that completes while all slots are full is dropped, and `ovf_flag` is set. The flag stays set until reset. The stored frames stay intact, and the frame after a dropped one is stored normally.
- R8: A copy takes exactly FRAME `clk_f` cycles, one word per cycle. A new handover request is raised only after the previous one has been acknowledged, given that a frame lasts longer than a copy plus the synchroniser delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Slow sensor sampling clock |
| rst_s | input | 1 | Synchronous active-high reset, slow domain |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW | Sample value |
| clk_f | input | 1 | Fast baseband clock |
| rst_f | input | 1 | Synchronous active-high reset, fast domain |
| tx_pop | input | 1 | Transmitter takes the word on tx_data |
| tx_data | output | DW | Oldest unread word |
| tx_wake | output | 1 | At least one complete frame is stored |
| ovf_flag | output | 1 | Sticky: a frame was dropped because the fast bank was full |

## Verification
The bench builds the block with DW=8, SLOW_DEPTH=8 and FAST_DEPTH=8. That gives four-word frames and two fast slots, so every half-switch, slot wrap and full-bank drop is reached within a few dozen samples. With the slow clock at ten fast cycles per sample, the bench sweeps single frames, back-to-back frame pairs and a triple burst that forces a drop. Every word it reads is checked against an arithmetic pattern, which exposes any lost, repeated or reordered sample.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int unsigned SFIFO_DW_DEF   = 8;
    localparam int unsigned SFIFO_SLOW_DEF = 512;
    localparam int unsigned SFIFO_FAST_DEF = 512;

    typedef enum logic {
        CP_IDLE = 1'b0,
        CP_MOVE = 1'b1
    } cp_state_e;

    // Number of frame slots a fast bank of the given depth provides.
    function automatic int unsigned slot_count(int unsigned fast_depth, int unsigned slow_depth);
        return fast_depth / (slow_depth / 2);
    endfunction

endpackage

// File: rtl/sfifo_sync2.sv
module sfifo_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
        end else begin
            meta_q <= d_in;
            stab_q <= meta_q;
        end
    end

    assign d_out = stab_q;
endmodule

// File: rtl/sfifo_slow_bank.sv
module sfifo_slow_bank #(
    parameter int unsigned DW         = sfifo_pkg::SFIFO_DW_DEF,
    parameter int unsigned SLOW_DEPTH = sfifo_pkg::SFIFO_SLOW_DEF
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [DW-1:0]                 wr_data,
    input  logic [$clog2(SLOW_DEPTH)-1:0] rd_addr,
    output logic [DW-1:0]                 rd_data,
    input  logic                          ack_tgl,
    output logic                          req_tgl,
    output logic                          pending
);
    localparam int unsigned FRAME = SLOW_DEPTH / 2;
    localparam int unsigned SAW   = $clog2(SLOW_DEPTH);
    localparam int unsigned CIW   = $clog2(FRAME);

    logic [DW-1:0]  mem [SLOW_DEPTH];
    logic [SAW-1:0] wr_ptr;
    logic           req_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            req_q  <= 1'b0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + SAW'(1);
            if (wr_ptr[CIW-1:0] == CIW'(FRAME - 1)) begin
                req_q <= ~req_q;
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign req_tgl = req_q;
    assign pending = req_q ^ ack_tgl;
endmodule

// File: rtl/sfifo_fast_bank.sv
module sfifo_fast_bank
    import sfifo_pkg::*;
#(
    parameter int unsigned DW         = SFIFO_DW_DEF,
    parameter int unsigned SLOW_DEPTH = SFIFO_SLOW_DEF,
    parameter int unsigned FAST_DEPTH = SFIFO_FAST_DEF
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  req_tgl,
    input  logic [DW-1:0]                         slow_rd_data,
    output logic [$clog2(SLOW_DEPTH)-1:0]         slow_rd_addr,
    output logic                                  ack_tgl,
    input  logic                                  pop,
    output logic [DW-1:0]                         data_out,
    output logic                                  wake,
    output logic                                  ovf,
    output logic                                  busy,
    output logic [$clog2(FAST_DEPTH)-1:0]         rd_ptr_o,
    output logic [$clog2(slot_count(FAST_DEPTH, SLOW_DEPTH)+1)-1:0] frames_o
);
    localparam int unsigned FRAME = SLOW_DEPTH / 2;
    localparam int unsigned NSLOT = slot_count(FAST_DEPTH, SLOW_DEPTH);
    localparam int unsigned FAW   = $clog2(FAST_DEPTH);
    localparam int unsigned CIW   = $clog2(FRAME);
    localparam int unsigned SW    = $clog2(NSLOT);
    localparam int unsigned CW    = $clog2(NSLOT + 1);

    logic [DW-1:0]  mem [FAST_DEPTH];
    cp_state_e      state;
    logic [CIW-1:0] cp_idx;
    logic           half;
    logic           seen;
    logic           ack_q;
    logic           ovf_q;
    logic [CW-1:0]  frames;
    logic [FAW-1:0] rd_ptr;
    logic [SW-1:0]  wslot;

    logic pop_ok;
    logic last_word;
    logic done;

    always_comb begin
        pop_ok    = pop && (frames != '0);
        last_word = pop_ok && (rd_ptr[CIW-1:0] == CIW'(FRAME - 1));
        done      = (state == CP_MOVE) && (cp_idx == CIW'(FRAME - 1));
    end

    always_ff @(posedge clk) begin
        if (state == CP_MOVE) begin
            mem[{wslot, cp_idx}] <= slow_rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CP_IDLE;
            cp_idx <= '0;
            half   <= 1'b0;
            seen   <= 1'b0;
            ack_q  <= 1'b0;
            ovf_q  <= 1'b0;
            frames <= '0;
            rd_ptr <= '0;
            wslot  <= '0;
        end else begin
            case (state)
                CP_IDLE: begin
                    if (req_tgl != seen) begin
                        seen <= req_tgl;
                        if (frames == CW'(NSLOT)) begin
                            ovf_q <= 1'b1;
                            half  <= ~half;
                            ack_q <= ~ack_q;
                        end else begin
                            state  <= CP_MOVE;
                            cp_idx <= '0;
                        end
                    end
                end
                CP_MOVE: begin
                    cp_idx <= cp_idx + CIW'(1);
                    if (done) begin
                        state <= CP_IDLE;
                        wslot <= wslot + SW'(1);
                        half  <= ~half;
                        ack_q <= ~ack_q;
                    end
                end
                default: state <= CP_IDLE;
            endcase
            frames <= frames + CW'(done) - CW'(last_word);
            rd_ptr <= rd_ptr + FAW'(pop_ok);
        end
    end

    assign slow_rd_addr = {half, cp_idx};
    assign ack_tgl      = ack_q;
    assign data_out     = mem[rd_ptr];
    assign wake         = (frames != '0);
    assign ovf          = ovf_q;
    assign busy         = (state == CP_MOVE);
    assign rd_ptr_o     = rd_ptr;
    assign frames_o     = frames;
endmodule

// File: rtl/dual_rate_sensor_fifo.sv
module dual_rate_sensor_fifo
    import sfifo_pkg::*;
#(
    parameter int unsigned DW         = SFIFO_DW_DEF,
    parameter int unsigned SLOW_DEPTH = SFIFO_SLOW_DEF,
    parameter int unsigned FAST_DEPTH = SFIFO_FAST_DEF
) (
    input  logic          clk_s,
    input  logic          rst_s,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    input  logic          clk_f,
    input  logic          rst_f,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_data,
    output logic          tx_wake,
    output logic          ovf_flag
);
    localparam int unsigned FRAME_W = SLOW_DEPTH / 2;
    localparam int unsigned NSLOT   = slot_count(FAST_DEPTH, SLOW_DEPTH);
    localparam int unsigned SAW     = $clog2(SLOW_DEPTH);
    localparam int unsigned FAW     = $clog2(FAST_DEPTH);
    localparam int unsigned CW      = $clog2(NSLOT + 1);

    logic           req_tgl;
    logic           req_f;
    logic           ack_tgl;
    logic           ack_s;
    logic           pending;
    logic           busy;
    logic [SAW-1:0] slow_addr;
    logic [DW-1:0]  slow_word;
    logic [FAW-1:0] rd_ptr;
    logic [CW-1:0]  frames;

    sfifo_slow_bank #(.DW(DW), .SLOW_DEPTH(SLOW_DEPTH)) u_slow (
        .clk     (clk_s),
        .rst     (rst_s),
        .wr_en   (smp_valid),
        .wr_data (smp_data),
        .rd_addr (slow_addr),
        .rd_data (slow_word),
        .ack_tgl (ack_s),
        .req_tgl (req_tgl),
        .pending (pending)
    );

    sfifo_sync2 u_req_sync (.clk(clk_f), .rst(rst_f), .d_in(req_tgl), .d_out(req_f));
    sfifo_sync2 u_ack_sync (.clk(clk_s), .rst(rst_s), .d_in(ack_tgl), .d_out(ack_s));

    sfifo_fast_bank #(.DW(DW), .SLOW_DEPTH(SLOW_DEPTH), .FAST_DEPTH(FAST_DEPTH)) u_fast (
        .clk          (clk_f),
        .rst          (rst_f),
        .req_tgl      (req_f),
        .slow_rd_data (slow_word),
        .slow_rd_addr (slow_addr),
        .ack_tgl      (ack_tgl),
        .pop          (tx_pop),
        .data_out     (tx_data),
        .wake         (tx_wake),
        .ovf          (ovf_flag),
        .busy         (busy),
        .rd_ptr_o     (rd_ptr),
        .frames_o     (frames)
    );
endmodule

// File: rtl/dual_rate_sensor_fifo_chk.sv
module dual_rate_sensor_fifo_chk #(
    parameter int unsigned FRAME = 4,
    parameter int unsigned FAW   = 3,
    parameter int unsigned CW    = 2
) (
    input logic           clk_s,
    input logic           rst_s,
    input logic           clk_f,
    input logic           rst_f,
    input logic           tx_pop,
    input logic           tx_wake,
    input logic           ovf_flag,
    input logic           busy,
    input logic           req_tgl,
    input logic           pending,
    input logic [FAW-1:0] rd_ptr,
    input logic [CW-1:0]  frames
);
    int unsigned busy_cnt;

    always_ff @(posedge clk_f) begin
        if (rst_f || !busy) busy_cnt <= 0;
        else                busy_cnt <= busy_cnt + 1;
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk_f) rst_f |=> (!tx_wake && !ovf_flag && frames == '0));
    // R7
    a_r7_ovf_sticky: assert property (@(posedge clk_f) disable iff (rst_f) ovf_flag |=> ovf_flag);
    // R5
    a_r5_pop_ignored: assert property (@(posedge clk_f) disable iff (rst_f) !tx_wake |=> $stable(rd_ptr));
    // R4
    a_r4_pop_advances: assert property (@(posedge clk_f) disable iff (rst_f) (tx_wake && tx_pop) |=> (rd_ptr != $past(rd_ptr)));
    // R8
    a_r8_copy_bounded: assert property (@(posedge clk_f) disable iff (rst_f) busy |-> (busy_cnt < FRAME));
    // R8
    a_r8_req_after_ack: assert property (@(posedge clk_s) disable iff (rst_s) (req_tgl != $past(req_tgl)) |-> !$past(pending));
endmodule

bind dual_rate_sensor_fifo dual_rate_sensor_fifo_chk #(
    .FRAME (FRAME_W),
    .FAW   (FAW),
    .CW    (CW)
) u_chk (
    .clk_s    (clk_s),
    .rst_s    (rst_s),
    .clk_f    (clk_f),
    .rst_f    (rst_f),
    .tx_pop   (tx_pop),
    .tx_wake  (tx_wake),
    .ovf_flag (ovf_flag),
    .busy     (busy),
    .req_tgl  (req_tgl),
    .pending  (pending),
    .rd_ptr   (rd_ptr),
    .frames   (frames)
);

// File: tb/dual_rate_sensor_fifo_bench.sv
module dual_rate_sensor_fifo_bench;
    localparam int DW = 8;
    localparam int SD = 8;
    localparam int FD = 8;
    localparam int FR = SD / 2;

    logic          clk_s = 1'b0;
    logic          clk_f = 1'b0;
    logic          rst_s = 1'b1;
    logic          rst_f = 1'b1;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          tx_pop = 1'b0;
    logic [DW-1:0] tx_data;
    logic          tx_wake;
    logic          ovf_flag;

    int n_run  = 0;
    int n_fail = 0;

    always #2  clk_f = ~clk_f;
    always #20 clk_s = ~clk_s;

    dual_rate_sensor_fifo #(.DW(DW), .SLOW_DEPTH(SD), .FAST_DEPTH(FD)) u_dual_rate_sensor_fifo (
        .clk_s(clk_s), .rst_s(rst_s), .smp_valid(smp_valid), .smp_data(smp_data),
        .clk_f(clk_f), .rst_f(rst_f), .tx_pop(tx_pop), .tx_data(tx_data),
        .tx_wake(tx_wake), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pat(input int idx);
        return (idx * 37 + 11) & 8'hFF;
    endfunction

    task automatic do_reset();
        rst_s = 1'b1;
        rst_f = 1'b1;
        repeat (3) @(posedge clk_s);
        @(negedge clk_s);
        rst_s = 1'b0;
        @(negedge clk_f);
        rst_f = 1'b0;
    endtask

    // Write count samples on consecutive slow cycles, pattern index from first.
    task automatic put(input int first, input int count);
        for (int i = 0; i < count; i++) begin
            @(negedge clk_s);
            smp_valid = 1'b1;
            smp_data  = DW'(pat(first + i));
        end
        @(negedge clk_s);
        smp_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk_s);
    endtask

    // Read count words back to back and compare with the pattern.
    task automatic take(input string tag, input int first, input int count);
        for (int i = 0; i < count; i++) begin
            @(negedge clk_f);
            chk(tag, int'(tx_data), pat(first + i));
            tx_pop = 1'b1;
        end
        @(negedge clk_f);
        tx_pop = 1'b0;
    endtask

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int idx;
        do_reset();
        @(negedge clk_f);
        chk("R1 wake after reset", int'(tx_wake), 0);
        chk("R1 ovf after reset", int'(ovf_flag), 0);

        // R5: pops with nothing stored must be ignored
        for (int i = 0; i < 3; i++) begin
            @(negedge clk_f);
            tx_pop = 1'b1;
            chk("R5 wake stays low", int'(tx_wake), 0);
        end
        @(negedge clk_f);
        tx_pop = 1'b0;

        // R2 / R3 / R4: single frames swept over several halves and slots
        idx = 0;
        for (int f = 0; f < 6; f++) begin
            put(idx, FR - 1);
            settle();
            @(negedge clk_f);
            chk("R2 no frame before half full", int'(tx_wake), 0);
            put(idx + FR - 1, 1);
            settle();
            @(negedge clk_f);
            chk("R3 wake after frame", int'(tx_wake), 1);
            take("R4 R5 single frame order", idx, FR);
            @(negedge clk_f);
            chk("R3 wake low after drain", int'(tx_wake), 0);
            idx += FR;
        end

        // R6: back-to-back frame pairs, no gap in sampling
        for (int p = 0; p < 4; p++) begin
            put(idx, 2 * FR);
            settle();
            @(negedge clk_f);
            chk("R6 wake after pair", int'(tx_wake), 1);
            take("R6 R4 pair order", idx, 2 * FR);
            @(negedge clk_f);
            chk("R3 wake low after pair", int'(tx_wake), 0);
            idx += 2 * FR;
        end

        // R7: three frames with no reads; third is dropped
        chk("R7 ovf clear before burst", int'(ovf_flag), 0);
        put(idx, 3 * FR);
        settle();
        @(negedge clk_f);
        chk("R7 ovf set", int'(ovf_flag), 1);
        take("R7 kept frames intact", idx, 2 * FR);
        @(negedge clk_f);
        chk("R7 dropped frame absent", int'(tx_wake), 0);
        idx += 3 * FR;
        put(idx, FR);
        settle();
        take("R7 frame after drop", idx, FR);
        @(negedge clk_f);
        chk("R7 ovf sticky", int'(ovf_flag), 1);

        do_reset();
        @(negedge clk_f);
        chk("R1 ovf cleared by reset", int'(ovf_flag), 0);
        chk("R1 wake cleared by reset", int'(tx_wake), 0);
        put(500, FR);
        settle();
        take("R2 first frame after reset", 500, FR);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule